// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the control unit and register-transfer datapath of a small processor with one working register. It holds a program counter, a memory address register, a memory buffer register, an instruction register and the working register. It drives a synchronous single-port memory through an address, write data, read data and separate read and write strobes. One interrupt request line comes in. A two-bit phase code and a step counter inside each phase pick the register transfers done in every clock. The phase codes are fetch 00, indirect 01, execute 10 and interrupt 11.

The instruction word is 16 bits wide. Bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 are the memory address. The opcodes are: 0 halts the machine, 1 adds a memory word to the working register, 2 increments a memory word and skips the next instruction when the result is zero, 3 stores the return address at the target and then continues at target+1, and 4 enables interrupts. Every other opcode does nothing. When an interrupt is taken, the return address is stored at a fixed save location and control passes to a fixed service address.

Top module: `icyc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the working register and the step counter. It sets the phase to fetch (00), disables interrupts and clears `halted`.
- R2: The phase output follows fetch, then indirect (01) when bit 11 of the fetched word is set, then execute (10), then interrupt (11) or fetch. Indirect is only ever entered from fetch.
- R3: Fetch takes three clocks. It issues a read at the program counter in its first clock, loads the buffer and increments the program counter in its second, and loads the instruction register in its third.
- R4: The indirect phase takes three clocks. It reads the word at the instruction address and replaces the 11-bit address field of the instruction with bits 10:0 of that word.
- R5: Opcode 1 takes three execute clocks and adds the memory word at the effective address to the working register, modulo 2^16.
- R6: Opcode 2 takes four execute clocks and writes the word plus one, modulo 2^16, back to the same address. When that result is zero, the program counter is incremented once more, which skips the next instruction.
- R7: Opcode 3 takes three execute clocks. It writes the address of the next instruction to the target word, and execution continues at target+1.
- R8: Opcode 4 enables interrupts after one execute clock. The instruction that enables interrupts is itself not followed by an interrupt. After a later execute phase that sees `irq` high while interrupts are enabled, the interrupt phase runs. In three clocks it writes the program counter to SAVE_ADDR, sets the program counter to ISR_ADDR and disables interrupts. While interrupts are disabled, `irq` has no effect.
- R9: Opcode 0 raises `halted` at the end of its first execute clock. After that, the program counter, phase and working register hold and no memory strobe is issued until reset.
- R10: Opcodes 5 to 15 take one execute clock and change neither the working register nor memory.
- R11: A read strobe returns data one clock later. The address is valid in the same clock as its strobe. A write lands at the edge that ends its clock. `mem_rd` and `mem_wr` are never high together, and writes occur only in the execute and interrupt phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Read data, valid one clock after `mem_rd` |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| phase | output | 2 | Current phase code |
| pc | output | 11 | Program counter |
| acc | output | 16 | Working register |
| halted | output | 1 | High once a halt has executed |

## Verification
A wrong step count or phase choice changes the number of clocks from reset to `halted`. The bench counts those clocks for every program, so an extra or missing step shows up at the end of the first affected instruction. A wrong register transfer shows up in the final working register, the program counter, or the memory words written for the store and increment operations. These are compared against sums and addresses computed in the bench across sweeps of operand values, skip boundaries, branch targets and unused opcodes. Bad interrupt entry shows up at the save location and in the later program counter within three clocks of the interrupt phase starting.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
    localparam int DW  = 16;
    localparam int AW  = 11;
    localparam int OPW = 4;
    localparam int SW  = 2;
    localparam int IND_BIT = AW;

    localparam logic [OPW-1:0] OPC_HALT = 4'd0;
    localparam logic [OPW-1:0] OPC_ADD  = 4'd1;
    localparam logic [OPW-1:0] OPC_ISZ  = 4'd2;
    localparam logic [OPW-1:0] OPC_BSA  = 4'd3;
    localparam logic [OPW-1:0] OPC_ION  = 4'd4;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_IND   = 2'b01,
        PH_EXE   = 2'b10,
        PH_INT   = 2'b11
    } phase_e;

    typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IRA, MAR_SAVE} mar_src_e;
    typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_INC} mbr_src_e;
    typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_IRA, PC_ISR, PC_SKIPZ} pc_src_e;

    typedef struct packed {
        mar_src_e mar;
        mbr_src_e mbr;
        pc_src_e  pc;
        logic     ir_ld;
        logic     ir_addr_ld;
        logic     acc_add;
        logic     rd;
        logic     wr;
        logic     ie_set;
        logic     last;
        logic     halt;
    } ctl_t;

    function automatic logic [OPW-1:0] op_of(input logic [DW-1:0] w);
        return w[DW-1 -: OPW];
    endfunction

    function automatic logic [AW-1:0] addr_of(input logic [DW-1:0] w);
        return w[AW-1:0];
    endfunction

    function automatic logic ind_of(input logic [DW-1:0] w);
        return w[IND_BIT];
    endfunction
endpackage

// File: rtl/icyc_decode.sv
module icyc_decode
    import icyc_pkg::*;
(
    input  phase_e          phase,
    input  logic [SW-1:0]   step,
    input  logic [OPW-1:0]  opcode,
    input  logic            run,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_FETCH: begin
                case (step)
                    2'd0: begin ctl.mar = MAR_PC; ctl.rd = 1'b1; end
                    2'd1: begin ctl.mbr = MBR_MEM; ctl.pc = PC_INC; end
                    default: begin ctl.ir_ld = 1'b1; ctl.last = 1'b1; end
                endcase
            end
            PH_IND: begin
                case (step)
                    2'd0: begin ctl.mar = MAR_IRA; ctl.rd = 1'b1; end
                    2'd1: ctl.mbr = MBR_MEM;
                    default: begin ctl.ir_addr_ld = 1'b1; ctl.last = 1'b1; end
                endcase
            end
            PH_INT: begin
                case (step)
                    2'd0: ctl.mbr = MBR_PC;
                    2'd1: begin ctl.mar = MAR_SAVE; ctl.pc = PC_ISR; end
                    default: begin ctl.wr = 1'b1; ctl.last = 1'b1; end
                endcase
            end
            default: begin
                case (opcode)
                    OPC_ADD: begin
                        case (step)
                            2'd0: begin ctl.mar = MAR_IRA; ctl.rd = 1'b1; end
                            2'd1: ctl.mbr = MBR_MEM;
                            default: begin ctl.acc_add = 1'b1; ctl.last = 1'b1; end
                        endcase
                    end
                    OPC_ISZ: begin
                        case (step)
                            2'd0: begin ctl.mar = MAR_IRA; ctl.rd = 1'b1; end
                            2'd1: ctl.mbr = MBR_MEM;
                            2'd2: ctl.mbr = MBR_INC;
                            default: begin
                                ctl.wr = 1'b1;
                                ctl.pc = PC_SKIPZ;
                                ctl.last = 1'b1;
                            end
                        endcase
                    end
                    OPC_BSA: begin
                        case (step)
                            2'd0: begin ctl.mar = MAR_IRA; ctl.mbr = MBR_PC; end
                            2'd1: begin ctl.pc = PC_IRA; ctl.wr = 1'b1; end
                            default: begin ctl.pc = PC_INC; ctl.last = 1'b1; end
                        endcase
                    end
                    OPC_HALT: ctl.halt = 1'b1;
                    OPC_ION: begin ctl.ie_set = 1'b1; ctl.last = 1'b1; end
                    default: ctl.last = 1'b1;
                endcase
            end
        endcase
        if (!run) ctl = '0;
    end
endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
    import icyc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic          ind_bit,
    input  logic          irq,
    output phase_e        phase_q,
    output logic [SW-1:0] step_q,
    output logic          ie_q,
    output logic          halted_q
);
    phase_e nxt_phase;

    always_comb begin
        unique case (phase_q)
            PH_FETCH: nxt_phase = ind_bit ? PH_IND : PH_EXE;
            PH_IND:   nxt_phase = PH_EXE;
            PH_EXE:   nxt_phase = (irq && ie_q) ? PH_INT : PH_FETCH;
            default:  nxt_phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_FETCH;
            step_q   <= '0;
            ie_q     <= 1'b0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (ctl.halt) begin
                halted_q <= 1'b1;
            end else if (ctl.last) begin
                step_q  <= '0;
                phase_q <= nxt_phase;
                if (ctl.ie_set) ie_q <= 1'b1;
                if (nxt_phase == PH_INT) ie_q <= 1'b0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/icyc_dpath.sv
module icyc_dpath
    import icyc_pkg::*;
#(
    parameter logic [AW-1:0] SAVE_ADDR = 11'h040,
    parameter logic [AW-1:0] ISR_ADDR  = 11'h041
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_q,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] ir_q,
    output logic [DW-1:0] mbr_q
);
    logic [AW-1:0] mar_q;
    logic [AW-1:0] mar_d;
    logic [AW-1:0] pc_inc;

    assign pc_inc = pc_q + 1'b1;

    always_comb begin
        unique case (ctl.mar)
            MAR_PC:   mar_d = pc_q;
            MAR_IRA:  mar_d = addr_of(ir_q);
            MAR_SAVE: mar_d = SAVE_ADDR;
            default:  mar_d = mar_q;
        endcase
    end

    // the address reaches memory in the same clock as the register load
    assign mem_addr  = mar_d;
    assign mem_wdata = mbr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            mbr_q <= '0;
            ir_q  <= '0;
            pc_q  <= '0;
            acc_q <= '0;
        end else begin
            mar_q <= mar_d;
            unique case (ctl.mbr)
                MBR_MEM: mbr_q <= mem_rdata;
                MBR_PC:  mbr_q <= {{(DW-AW){1'b0}}, pc_q};
                MBR_INC: mbr_q <= mbr_q + 1'b1;
                default: mbr_q <= mbr_q;
            endcase
            unique case (ctl.pc)
                PC_INC:   pc_q <= pc_inc;
                PC_IRA:   pc_q <= addr_of(ir_q);
                PC_ISR:   pc_q <= ISR_ADDR;
                PC_SKIPZ: if (mbr_q == '0) pc_q <= pc_inc;
                default:  pc_q <= pc_q;
            endcase
            if (ctl.ir_ld) begin
                ir_q <= mbr_q;
            end else if (ctl.ir_addr_ld) begin
                ir_q[AW-1:0] <= addr_of(mbr_q);
            end
            if (ctl.acc_add) acc_q <= acc_q + mbr_q;
        end
    end
endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
    import icyc_pkg::*;
#(
    parameter logic [AW-1:0] SAVE_ADDR = 11'h040,
    parameter logic [AW-1:0] ISR_ADDR  = 11'h041
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [1:0]    phase,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc,
    output logic          halted
);
    ctl_t          ctl;
    phase_e        phase_w;
    logic [SW-1:0] step_w;
    logic          ie_w;
    logic [DW-1:0] ir_w;
    logic [DW-1:0] mbr_w;

    icyc_decode u_dec (
        .phase  (phase_w),
        .step   (step_w),
        .opcode (op_of(ir_w)),
        .run    (!halted),
        .ctl    (ctl)
    );

    icyc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .ind_bit  (ind_of(mbr_w)),
        .irq      (irq),
        .phase_q  (phase_w),
        .step_q   (step_w),
        .ie_q     (ie_w),
        .halted_q (halted)
    );

    icyc_dpath #(
        .SAVE_ADDR (SAVE_ADDR),
        .ISR_ADDR  (ISR_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_q      (pc),
        .acc_q     (acc),
        .ir_q      (ir_w),
        .mbr_q     (mbr_w)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;
    assign phase  = phase_w;
endmodule

// File: rtl/icyc_chk.sv
module icyc_chk
    import icyc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [1:0]    phase,
    input logic [SW-1:0] step,
    input logic          ie,
    input logic          halted,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] pc
);
    p_rw_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_wr_phase_r11: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (phase == PH_EXE || phase == PH_INT));

    p_fetch_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && step == 2'd1 && !halted) |=> pc == $past(pc) + 1'b1);

    p_ind_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IND && $past(phase) != PH_IND) |-> $past(phase) == PH_FETCH);

    p_int_masked_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_INT |-> !ie);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(phase)));
endmodule

bind icyc_ctrl icyc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .step   (step_w),
    .ie     (ie_w),
    .halted (halted),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .pc     (pc)
);

// File: tb/sim_icyc_ctrl.sv
`timescale 1ns/1ps
module sim_icyc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [1:0]  phase;
    logic [10:0] pc;
    logic [15:0] acc;
    logic        halted;

    logic [15:0] mem [2048];
    int n_run = 0;
    int n_fail = 0;
    int cyc_total = 0;
    int cyc;
    logic saw_int;

    always #2.5 clk = ~clk;

    icyc_ctrl u0 (
        .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .phase(phase), .pc(pc), .acc(acc), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) if (!rst && phase == 2'b11) saw_int = 1'b1;

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc_total);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    endtask

    // resets, releases, clocks until halted; cyc = edges until halted
    task automatic run_prog();
        rst = 1'b1;
        saw_int = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!halted && cyc < 3000);
        if (!halted) chk("R9 halt reached", 32'd0, 32'd1);
    endtask

    initial begin
        logic [15:0] av [6];
        logic [15:0] bv [4];
        logic [15:0] zv [5];
        logic [10:0] tv [3];
        av = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFF, 16'h1234, 16'h8000};
        bv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h00FF};
        zv = '{16'hFFFE, 16'hFFFF, 16'h0000, 16'h0007, 16'h7FFF};
        tv = '{11'h200, 11'h3A0, 11'h7F0};

        // leave a halted machine, then check that reset clears it (R1)
        clear_mem();
        mem[0] = 16'h1100; mem[1] = 16'h0000; mem[11'h100] = 16'h4444;
        run_prog();
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 pc", {21'd0, pc}, 32'd0);
        chk("R1 acc", {16'd0, acc}, 32'd0);
        chk("R1 phase", {30'd0, phase}, 32'd0);
        chk("R1 halted", {31'd0, halted}, 32'd0);

        // R5, R4, R3, R2: direct add, indirect add, halt
        foreach (av[i]) begin
            foreach (bv[j]) begin
                clear_mem();
                mem[0] = 16'h1100;
                mem[1] = 16'h1901;
                mem[2] = 16'h0000;
                mem[11'h100] = av[i];
                mem[11'h101] = 16'h0102;
                mem[11'h102] = bv[j];
                run_prog();
                chk("R5 R4 acc sum", {16'd0, acc}, {16'd0, av[i] + bv[j]});
                chk("R3 pc after halt", {21'd0, pc}, 32'd3);
                chk("R2 R3 R4 clocks", cyc, 32'd19);
                chk("R2 phase at halt", {30'd0, phase}, 32'd2);
            end
        end

        // R9: machine stays frozen
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R9 pc frozen", {21'd0, pc}, 32'd3);
        chk("R9 halted held", {31'd0, halted}, 32'd1);
        chk("R9 no write", {16'd0, mem[11'h102]}, {16'd0, bv[3]});

        // R6: increment and skip on zero
        foreach (zv[i]) begin
            logic [15:0] inc;
            inc = zv[i] + 16'h0001;
            clear_mem();
            mem[0] = 16'h2100;
            mem[1] = 16'h0000;
            mem[2] = 16'h0000;
            mem[11'h100] = zv[i];
            run_prog();
            chk("R6 stored value", {16'd0, mem[11'h100]}, {16'd0, inc});
            chk("R6 skip pc", {21'd0, pc}, (inc == 16'h0000) ? 32'd3 : 32'd2);
            chk("R6 clocks", cyc, (inc == 16'h0000) ? 32'd11 : 32'd11);
        end

        // R7: branch and save the return address
        foreach (tv[i]) begin
            clear_mem();
            mem[0] = 16'h3000 | {5'd0, tv[i]};
            mem[1] = 16'h0000;
            mem[tv[i] + 11'd1] = 16'h1100;
            mem[tv[i] + 11'd2] = 16'h0000;
            mem[11'h100] = 16'h0055 + 16'(i);
            run_prog();
            chk("R7 saved return", {16'd0, mem[tv[i]]}, 32'd1);
            chk("R7 resumed target+1", {16'd0, acc}, 32'h55 + i);
            chk("R7 final pc", {21'd0, pc}, {21'd0, tv[i] + 11'd3});
            chk("R7 clocks", cyc, 32'd16);
        end

        // R8: interrupt taken after enabling
        clear_mem();
        mem[0] = 16'h4000;
        mem[1] = 16'h1100;
        mem[2] = 16'h0000;
        mem[11'h040] = 16'hBEEF;
        mem[11'h041] = 16'h1101;
        mem[11'h042] = 16'h0000;
        mem[11'h100] = 16'h0300;
        mem[11'h101] = 16'h0021;
        irq = 1'b1;
        run_prog();
        chk("R8 saved pc", {16'd0, mem[11'h040]}, 32'd2);
        chk("R8 acc", {16'd0, acc}, 32'h0321);
        chk("R8 pc in service", {21'd0, pc}, 32'h043);
        chk("R8 interrupt phase seen", {31'd0, saw_int}, 32'd1);
        chk("R8 clocks", cyc, 32'd23);

        // R8: request ignored while disabled
        clear_mem();
        mem[0] = 16'h1100;
        mem[1] = 16'h0000;
        mem[11'h040] = 16'hBEEF;
        mem[11'h100] = 16'h0009;
        run_prog();
        chk("R8 masked save untouched", {16'd0, mem[11'h040]}, 32'hBEEF);
        chk("R8 masked pc", {21'd0, pc}, 32'd2);
        chk("R8 masked no phase 11", {31'd0, saw_int}, 32'd0);
        irq = 1'b0;

        // R10: unused opcodes do nothing
        for (int op = 5; op < 16; op++) begin
            clear_mem();
            mem[0] = {op[3:0], 12'h100};
            mem[1] = 16'h0000;
            mem[11'h100] = 16'h1111;
            run_prog();
            chk("R10 acc", {16'd0, acc}, 32'd0);
            chk("R10 memory", {16'd0, mem[11'h100]}, 32'h1111);
            chk("R10 pc", {21'd0, pc}, 32'd2);
            chk("R10 R11 clocks", cyc, 32'd8);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule